// File: doc/BRIEF.md
# TDM Line Diagnostic Router with Receive Frame Alignment

This block sits between a time-division-multiplexed serial line and an internal serial channel. One bit clock serves both directions. On every rising edge the block takes one line receive bit and one channel transmit bit. It chooses what leaves on the line transmit pin, whether the line request is raised, and which bit goes to the channel receiver. The choice depends on a 2-bit diagnostic mode that is latched at each frame sync.

The block also finds where a receive frame starts. A 2-bit delay field gives 0 to 3 bit clocks between the frame sync and the first receive bit. A one-cycle strobe marks that bit on the channel receive output. The delay setting shapes only this strobe and never moves any transmit timing. The mode can be changed at any time, but a new value is held off until the next frame sync, so a frame in flight is never split between two routings.

Top module: `tdm_diag_loop`

## Requirements
- R1: Mode code on `cfg_mode_i`: 2'b00 normal, 2'b01 automatic echo, 2'b10 internal loopback, 2'b11 isolated loopback. The code is taken on a rising edge where `fsync_i` is 1 and governs that edge's bits and all later edges. All routed outputs are registered, so they appear one cycle after the edge that sampled the inputs.
- R2: Normal mode. `line_txd_o` carries `ch_txd_i` when `line_gnt_i` is 1, and is 1 when grant is 0. `line_req_o` follows `ch_req_i`. `ch_rxd_o` carries `line_rxd_i`.
- R3: Automatic echo mode. `line_txd_o` repeats `line_rxd_i` bit by bit, one cycle later. Grant and `ch_txd_i` have no effect. `line_req_o` stays 0. `ch_rxd_o` carries `line_rxd_i`.
- R4: Internal loopback mode. `ch_rxd_o` carries `ch_txd_i`. `line_txd_o` also carries `ch_txd_i`, whatever the grant. `line_req_o` follows `ch_req_i`.
- R5: Isolated loopback mode. `ch_rxd_o` carries `ch_txd_i`. `line_txd_o` is held at 1 and `line_req_o` is held at 0.
- R6: When `cfg_dly_i` is 0 at a sync edge, `rx_start_o` is 1 in the cycle after that edge. In that same cycle `ch_rxd_o` shows the bit sampled on the sync edge.
- R7: When `cfg_dly_i` is d (1 to 3) at a sync edge, `rx_start_o` pulses for one cycle exactly d cycles later than it would for d = 0. It stays 0 at every other point of that window.
- R8: A sync that arrives while a delay count is running restarts the count from the new sync. The strobe of the abandoned count never appears.
- R9: While `rst_ni` is 0: `line_txd_o` is 1, `line_req_o` is 0, `ch_rxd_o` is 0 and `rx_start_o` is 0. The latched mode resets to normal.
- R10: A change of `cfg_mode_i` without a sync has no effect on the routing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Bit clock shared by transmit and receive |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fsync_i | input | 1 | Frame sync, sampled on the rising edge |
| cfg_mode_i | input | 2 | Diagnostic mode code, latched at sync |
| cfg_dly_i | input | 2 | Receive sync-to-first-bit delay in bit clocks |
| line_rxd_i | input | 1 | Serial receive data from the line |
| line_gnt_i | input | 1 | Line grant (used only in normal mode) |
| ch_txd_i | input | 1 | Serial transmit data from the channel |
| ch_req_i | input | 1 | Channel wants to transmit |
| line_txd_o | output | 1 | Serial transmit data to the line, idle 1 |
| line_req_o | output | 1 | Request to the line, active high |
| ch_rxd_o | output | 1 | Serial receive data to the channel |
| rx_start_o | output | 1 | One-cycle strobe on the first receive frame bit |

## Verification
The hardest case to reach is a mode written without a sync while the old mode is still routing bits. The stimulus latches isolated loopback, then presents normal-mode inputs with the sync held low. The line pins must stay quiet until a later sync. A second hard case is a sync that lands in the middle of a 3-cycle delay count. The bench issues two syncs two cycles apart and checks that only the second one produces a strobe, exactly three cycles after it.

// File: rtl/tdm_diag_pkg.sv
package tdm_diag_pkg;

    typedef enum logic [1:0] {
        MODE_NORMAL  = 2'b00,
        MODE_ECHO    = 2'b01,
        MODE_INTLOOP = 2'b10,
        MODE_ISOLOOP = 2'b11
    } diag_mode_e;

    // Idle levels of the line-side outputs
    localparam logic LINE_TXD_IDLE = 1'b1;
    localparam logic LINE_REQ_IDLE = 1'b0;

    typedef struct packed {
        logic txd;
        logic req;
        logic rxd;
    } route_bits_t;

endpackage

// File: rtl/tdm_mode_latch.sv
module tdm_mode_latch
    import tdm_diag_pkg::*;
(
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       fsync_i,
    input  diag_mode_e cfg_mode_i,
    output diag_mode_e eff_mode_o
);

    diag_mode_e mode_d, mode_q;

    // A new code is applied from the sync edge itself onward
    always_comb begin
        mode_d     = mode_q;
        eff_mode_o = mode_q;
        if (fsync_i) begin
            mode_d     = cfg_mode_i;
            eff_mode_o = cfg_mode_i;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) mode_q <= MODE_NORMAL;
        else         mode_q <= mode_d;
    end

endmodule

// File: rtl/tdm_rx_align.sv
module tdm_rx_align #(
    parameter int DLY_W = 2
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             fsync_i,
    input  logic [DLY_W-1:0] cfg_dly_i,
    output logic             start_o
);

    localparam logic [DLY_W-1:0] CNT_ZERO = '0;
    localparam logic [DLY_W-1:0] CNT_LAST = {{(DLY_W-1){1'b0}}, 1'b1};

    typedef struct packed {
        logic [DLY_W-1:0] cnt;
        logic             start;
    } align_t;

    align_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.start = 1'b0;
        if (fsync_i) begin
            // A fresh sync always overrides a running count
            if (cfg_dly_i == CNT_ZERO) begin
                st_d.start = 1'b1;
                st_d.cnt   = CNT_ZERO;
            end else begin
                st_d.cnt   = cfg_dly_i;
            end
        end else if (st_q.cnt != CNT_ZERO) begin
            if (st_q.cnt == CNT_LAST) st_d.start = 1'b1;
            st_d.cnt = st_q.cnt - CNT_LAST;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign start_o = st_q.start;

endmodule

// File: rtl/tdm_route.sv
module tdm_route
    import tdm_diag_pkg::*;
(
    input  diag_mode_e  mode_i,
    input  logic        line_rxd_i,
    input  logic        line_gnt_i,
    input  logic        ch_txd_i,
    input  logic        ch_req_i,
    output route_bits_t bits_o
);

    always_comb begin
        bits_o.txd = LINE_TXD_IDLE;
        bits_o.req = LINE_REQ_IDLE;
        bits_o.rxd = line_rxd_i;
        unique case (mode_i)
            MODE_NORMAL: begin
                bits_o.txd = line_gnt_i ? ch_txd_i : LINE_TXD_IDLE;
                bits_o.req = ch_req_i;
            end
            MODE_ECHO: begin
                bits_o.txd = line_rxd_i;
            end
            MODE_INTLOOP: begin
                bits_o.txd = ch_txd_i;
                bits_o.req = ch_req_i;
                bits_o.rxd = ch_txd_i;
            end
            MODE_ISOLOOP: begin
                bits_o.rxd = ch_txd_i;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/tdm_diag_loop.sv
module tdm_diag_loop
    import tdm_diag_pkg::*;
#(
    parameter int DLY_W = 2
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             fsync_i,
    input  logic [1:0]       cfg_mode_i,
    input  logic [DLY_W-1:0] cfg_dly_i,
    input  logic             line_rxd_i,
    input  logic             line_gnt_i,
    input  logic             ch_txd_i,
    input  logic             ch_req_i,
    output logic             line_txd_o,
    output logic             line_req_o,
    output logic             ch_rxd_o,
    output logic             rx_start_o
);

    diag_mode_e  eff_mode;
    route_bits_t out_d, out_q;

    localparam route_bits_t OUT_RESET = '{txd: LINE_TXD_IDLE, req: LINE_REQ_IDLE, rxd: 1'b0};

    tdm_mode_latch u_mode (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .fsync_i    (fsync_i),
        .cfg_mode_i (diag_mode_e'(cfg_mode_i)),
        .eff_mode_o (eff_mode)
    );

    tdm_route u_route (
        .mode_i     (eff_mode),
        .line_rxd_i (line_rxd_i),
        .line_gnt_i (line_gnt_i),
        .ch_txd_i   (ch_txd_i),
        .ch_req_i   (ch_req_i),
        .bits_o     (out_d)
    );

    tdm_rx_align #(.DLY_W(DLY_W)) u_align (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .fsync_i   (fsync_i),
        .cfg_dly_i (cfg_dly_i),
        .start_o   (rx_start_o)
    );

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) out_q <= OUT_RESET;
        else         out_q <= out_d;
    end

    assign line_txd_o = out_q.txd;
    assign line_req_o = out_q.req;
    assign ch_rxd_o   = out_q.rxd;

endmodule

// File: rtl/tdm_diag_checker.sv
module tdm_diag_checker #(
    parameter int DLY_W = 2
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic             fsync_i,
    input logic [DLY_W-1:0] cfg_dly_i,
    input logic [1:0]       eff_mode,
    input logic             line_rxd_i,
    input logic             line_gnt_i,
    input logic             ch_txd_i,
    input logic             line_txd_o,
    input logic             line_req_o,
    input logic             ch_rxd_o,
    input logic             rx_start_o
);

    logic armed_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) armed_q <= 1'b0;
        else         armed_q <= 1'b1;
    end

    AST_ECHO_RETX: assert property (@(posedge clk_i) disable iff (!rst_ni)
        armed_q && $past(eff_mode) == 2'b01 |-> line_txd_o == $past(line_rxd_i)); // R3

    AST_ISO_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
        armed_q && $past(eff_mode) == 2'b11 |-> line_txd_o && !line_req_o); // R5

    AST_NOGRANT_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        armed_q && $past(eff_mode) == 2'b00 && !$past(line_gnt_i) |-> line_txd_o); // R2

    AST_LOOP_RXD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        armed_q && $past(eff_mode[1]) |-> ch_rxd_o == $past(ch_txd_i)); // R4

    AST_ZERO_DLY_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
        armed_q && $past(fsync_i) && $past(cfg_dly_i) == '0 |-> rx_start_o); // R6

    always @(negedge clk_i) begin
        if (!rst_ni) begin
            AST_RESET_IDLE: assert (line_txd_o && !line_req_o && !rx_start_o); // R9
        end
    end

endmodule

bind tdm_diag_loop tdm_diag_checker #(.DLY_W(DLY_W)) u_chk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .fsync_i    (fsync_i),
    .cfg_dly_i  (cfg_dly_i),
    .eff_mode   (eff_mode),
    .line_rxd_i (line_rxd_i),
    .line_gnt_i (line_gnt_i),
    .ch_txd_i   (ch_txd_i),
    .line_txd_o (line_txd_o),
    .line_req_o (line_req_o),
    .ch_rxd_o   (ch_rxd_o),
    .rx_start_o (rx_start_o)
);

// File: tb/tb_tdm_diag_loop.sv
module tb_tdm_diag_loop;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       fsync = 1'b0;
    logic [1:0] mode = 2'b00;
    logic [1:0] dly = 2'b00;
    logic       rxd = 1'b0;
    logic       gnt = 1'b0;
    logic       txd = 1'b0;
    logic       req = 1'b0;
    logic       l_txd, l_req, c_rxd, start;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    tdm_diag_loop dut (
        .clk_i      (clk),
        .rst_ni     (rst_n),
        .fsync_i    (fsync),
        .cfg_mode_i (mode),
        .cfg_dly_i  (dly),
        .line_rxd_i (rxd),
        .line_gnt_i (gnt),
        .ch_txd_i   (txd),
        .ch_req_i   (req),
        .line_txd_o (l_txd),
        .line_req_o (l_req),
        .ch_rxd_o   (c_rxd),
        .rx_start_o (start)
    );

    // {mode[1:0], gnt, req, rxd, txd, exp_txd, exp_req, exp_rxd}
    localparam logic [8:0] VEC [12] = '{
        9'b00_1_1_0_1_1_1_0,
        9'b00_0_1_1_0_1_1_1,
        9'b00_1_0_1_0_0_0_1,
        9'b01_1_1_0_1_0_0_0,
        9'b01_0_1_1_0_1_0_1,
        9'b01_1_0_0_0_0_0_0,
        9'b10_0_1_1_0_0_1_0,
        9'b10_1_0_0_1_1_0_1,
        9'b10_0_0_1_1_1_0_1,
        9'b11_1_1_0_0_1_0_0,
        9'b11_0_1_1_1_1_0_1,
        9'b11_1_0_1_0_1_0_0
    };

    task automatic check(input string tag, input logic [3:0] act, input logic [3:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: {txd,req,rxd,start} actual %b expected %b", tag, act, exp);
        end
    endtask

    // Inputs are set between edges, outputs read 1 ns after the edge
    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    function automatic string mode_tag(input logic [1:0] m);
        case (m)
            2'b00:   return "R2 normal";
            2'b01:   return "R3 echo";
            2'b10:   return "R4 internal loop";
            default: return "R5 isolated loop";
        endcase
    endfunction

    initial begin
        #200000;
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        // R9: values while reset is held
        #5;
        check("R9 reset", {l_txd, l_req, c_rxd, start}, 4'b1000);
        rst_n = 1'b1;
        #4;

        // Vector walk: every entry is applied on a sync edge, delay 0 (R1, R6)
        foreach (VEC[i]) begin
            {mode, gnt, req, rxd, txd} = VEC[i][8:3];
            fsync = 1'b1;
            dly   = 2'b00;
            tick();
            check($sformatf("R1 %s vec%0d", mode_tag(VEC[i][8:7]), i),
                  {l_txd, l_req, c_rxd, start}, {VEC[i][2:0], 1'b1});
        end
        fsync = 1'b0;

        // R3: echo bit stream, grant and channel data toggled against it
        mode = 2'b01; fsync = 1'b1; rxd = 1'b1; tick();
        fsync = 1'b0;
        for (int k = 0; k < 6; k++) begin
            logic prev;
            prev = rxd;
            rxd  = k[0];
            gnt  = ~k[1];
            txd  = ~rxd;
            tick();
            check("R3 echo stream", {l_txd, l_req, c_rxd, start}, {rxd, 1'b0, rxd, 1'b0});
            if (k == 0) check("R3 echo prior bit", {3'b000, prev}, 4'b0001);
        end

        // R10: latch isolated loopback, then change code without sync
        mode = 2'b11; fsync = 1'b1; tick();
        fsync = 1'b0; mode = 2'b00; gnt = 1'b1; req = 1'b1; txd = 1'b0; rxd = 1'b1;
        tick();
        check("R10 no sync, still isolated", {l_txd, l_req, c_rxd, start}, 4'b1000);
        tick();
        check("R10 no sync, second bit", {l_txd, l_req, c_rxd, start}, 4'b1000);
        fsync = 1'b1; tick();
        fsync = 1'b0;
        check("R10 applied at sync", {l_txd, l_req, c_rxd, start}, 4'b0111);

        // R7: strobe position for each non-zero delay
        for (int d = 1; d < 4; d++) begin
            dly = 2'(d); fsync = 1'b1; tick();
            fsync = 1'b0;
            for (int k = 0; k < 5; k++) begin
                n_chk++;
                if (start !== (k == d)) begin
                    n_bad++;
                    $display("FAIL R7 dly%0d cyc%0d: actual %b expected %b", d, k, start, (k == d));
                end
                tick();
            end
        end

        // R8: a second sync two cycles into a delay-3 count restarts it
        dly = 2'b11; fsync = 1'b1; tick();
        fsync = 1'b0; tick();
        fsync = 1'b1; tick();
        fsync = 1'b0;
        for (int k = 0; k < 5; k++) begin
            n_chk++;
            if (start !== (k == 3)) begin
                n_bad++;
                $display("FAIL R8 restart cyc%0d: actual %b expected %b", k, start, (k == 3));
            end
            tick();
        end

        // R9: reset mid-run returns the idle levels and normal mode
        mode = 2'b11; fsync = 1'b1; tick();
        fsync = 1'b0;
        rst_n = 1'b0; #1;
        check("R9 async reset", {l_txd, l_req, c_rxd, start}, 4'b1000);
        rst_n = 1'b1;
        gnt = 1'b1; txd = 1'b0; req = 1'b1; rxd = 1'b1;
        tick();
        check("R9 mode back to normal", {l_txd, l_req, c_rxd, start}, 4'b0110);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule